// File: doc/BRIEF.md
# Vectored Sixteen-Channel Priority Interrupt Controller

This block collects sixteen single-cycle event pulses and turns them into one active-low interrupt request toward a processor. Each channel carries four state bits: enable, pending, mask and in-service. Channel 15 has the highest priority and channel 0 the lowest. The channel number order, from 15 down to 0, is: general input 7, general input 6, timer A, receive full, receive error, transmit empty, transmit error, timer B, general input 5, general input 4, timer C, timer D, general input 3, general input 2, general input 1, general input 0.

When the processor acknowledges, the controller returns an 8-bit vector. Its upper nibble comes from a programmable vector register. Its lower nibble is the number of the winning channel. The controller also forms a priority chain with other controllers through an active-low enable-in and an active-low enable-out. A bit in the vector register selects how interrupts end. In automatic end-of-interrupt, nothing is remembered after an acknowledge. In software end-of-interrupt, the acknowledged channel is marked in service, and that mark holds back every channel at or below it until software clears it.

Registers are 8 bits wide and are accessed through a simple synchronous write strobe and a combinational read port. The register addresses are:

- 0 and 1: enable, channels 7..0 and 15..8.
- 2 and 3: pending, channels 7..0 and 15..8.
- 4 and 5: mask, channels 7..0 and 15..8.
- 6 and 7: in-service, channels 7..0 and 15..8.
- 8: vector register.

Top module: `irqc_top`

## Requirements
- R1: When several channels are eligible, the winner is the one with the highest channel number.
- R2: For an accepted acknowledge, `vecValid` is high in the cycle after `ackReq` and `vecOut` = {vector register bits 7:4, 4-bit winner number}. Otherwise `vecValid` and `vecOut` are 0.
- R3: An event on a channel whose enable bit is 0 does not set its pending bit. Writing 0 to an enable bit clears that channel's pending bit and leaves its in-service bit unchanged.
- R4: A channel whose mask bit is 0 still sets its pending bit but does not assert `irqN`. After the mask bit is set to 1, the channel competes at its normal priority.
- R5: A write to a pending or in-service byte clears each bit written as 0 and leaves each bit written as 1 unchanged. Software cannot set these bits.
- R6: An accepted acknowledge clears the winner's pending bit. If an enabled event arrives on that channel in the same cycle, the pending bit stays set.
- R7: Vector register bit 3 (S) selects the mode. With S=0, the in-service bits become and stay 0. With S=1, an accepted acknowledge sets the winner's in-service bit.
- R8: A channel is eligible when it is pending, its mask bit is 1, and no in-service bit is set at its own number or above. Blocked channels still set their pending bits. `irqN` is low exactly when an eligible channel exists.
- R9: `chainOutN` is low exactly when `chainInN` is low and no channel is eligible. An acknowledge is accepted only when `chainInN` is low and a channel is eligible; any other acknowledge changes no state and yields no vector.
- R10: Reset clears the enable, pending, mask and in-service bits and loads the vector register with 0x0F. Bits 2:0 of the vector register read as 0, so it reads back 0x08 after reset. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| evt | input | 16 | Event pulses, bit n = channel n |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (write and read) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data at `regAddr` |
| ackReq | input | 1 | Interrupt acknowledge strobe |
| chainInN | input | 1 | Active-low chain enable in |
| chainOutN | output | 1 | Active-low chain enable out |
| irqN | output | 1 | Active-low interrupt request |
| vecValid | output | 1 | Vector returned for the previous acknowledge |
| vecOut | output | 8 | Interrupt vector |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Event and acknowledge in the same cycle.** A design that lets the clear win would lose the new interrupt.
- **Write-zero-to-clear with ones in the data.** A design that stores the data directly would let software set pending or in-service bits.
- **The in-service ceiling.** This covers a lower channel that pends silently, and a higher channel that still breaks through. An off-by-one in the ceiling would either let the same channel nest or block a higher one.
- **Disabling a channel that is in service.** A design that also clears the in-service bit would drop the ceiling early.
- **Acknowledge with the chain input inactive.** A design that answers anyway would put two vectors on a shared bus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NCH       = 16;
  localparam int DW        = 8;
  localparam int IDW       = $clog2(NCH);
  localparam int NBYTE     = NCH / DW;
  localparam int EN_BASE   = 0;
  localparam int PEND_BASE = NBYTE;
  localparam int MASK_BASE = 2 * NBYTE;
  localparam int SVC_BASE  = 3 * NBYTE;
  localparam int VEC_ADDR  = 4 * NBYTE;
  localparam int NREG      = 4 * NBYTE + 1;
  localparam int AW        = $clog2(NREG);
  localparam logic [DW-1:0] VEC_RST = 8'h0F;
  localparam logic [DW-1:0] VEC_RD_MASK = 8'hF8;

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic [DW-1:0]   wdata;
    logic            ackTake;
  } strobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        st,
  input  logic [NCH-1:0] evt,
  input  logic [AW-1:0]  rdAddr,
  output logic [DW-1:0]  rdData,
  output logic           anyElig,
  output logic [IDW-1:0] winId,
  output logic [3:0]     vecHi
);
  logic [NCH-1:0] en, pend, msk, svc;
  logic [NCH-1:0] enNext, mskNext, pendClr, svcClr, blocked, elig, ackHot;
  logic [DW-1:0]  vecReg;
  logic           sMode;

  assign sMode = vecReg[3];
  assign vecHi = vecReg[7:4];

  always_comb begin
    enNext  = en;
    mskNext = msk;
    pendClr = '0;
    svcClr  = '0;
    for (int b = 0; b < NBYTE; b++) begin
      if (st.wrSel[EN_BASE + b]) begin
        enNext[b*DW +: DW]  = st.wdata;
        pendClr[b*DW +: DW] = ~st.wdata;
      end
      if (st.wrSel[PEND_BASE + b]) pendClr[b*DW +: DW] = pendClr[b*DW +: DW] | ~st.wdata;
      if (st.wrSel[MASK_BASE + b]) mskNext[b*DW +: DW] = st.wdata;
      if (st.wrSel[SVC_BASE + b])  svcClr[b*DW +: DW]  = ~st.wdata;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      acc = acc | svc[i];
      blocked[i] = acc;
    end
  end

  assign elig    = pend & msk & ~blocked;
  assign anyElig = |elig;

  always_comb begin
    winId = '0;
    for (int i = 0; i < NCH; i++) if (elig[i]) winId = IDW'(i);
  end

  always_comb begin
    ackHot = '0;
    if (st.ackTake) ackHot[winId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en     <= '0;
      pend   <= '0;
      msk    <= '0;
      svc    <= '0;
      vecReg <= VEC_RST;
    end else begin
      en   <= enNext;
      msk  <= mskNext;
      pend <= (pend & ~(pendClr | ackHot)) | (evt & enNext);
      svc  <= sMode ? ((svc & ~svcClr) | ackHot) : '0;
      if (st.wrSel[VEC_ADDR]) vecReg <= st.wdata;
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NBYTE; b++) begin
      if (int'(rdAddr) == EN_BASE + b)   rdData = en[b*DW +: DW];
      if (int'(rdAddr) == PEND_BASE + b) rdData = pend[b*DW +: DW];
      if (int'(rdAddr) == MASK_BASE + b) rdData = msk[b*DW +: DW];
      if (int'(rdAddr) == SVC_BASE + b)  rdData = svc[b*DW +: DW];
    end
    if (int'(rdAddr) == VEC_ADDR) rdData = vecReg & VEC_RD_MASK;
  end

  // R3: with every channel disabled and no register write, nothing can pend
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((en == '0) && (st.wrSel == '0)) |=> (pend == '0));
  // R6: the acknowledged channel loses its pending bit unless re-triggered
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (st.ackTake && !evt[winId]) |=> !pend[$past(winId)]);
  // R7: automatic mode empties the in-service bits
  a_r7_auto_no_svc: assert property (@(posedge clk) disable iff (!rstN)
    !sMode |=> (svc == '0));
  // R8: a winner always lies strictly above every in-service bit
  a_r8_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    anyElig |-> ((svc >> winId) == '0));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWr,
  input  logic [AW-1:0]  regAddr,
  input  logic [DW-1:0]  regWdata,
  input  logic           ackReq,
  input  logic           chainInN,
  input  logic           anyElig,
  input  logic [IDW-1:0] winId,
  input  logic [3:0]     vecHi,
  output strobe_t        st,
  output logic           irqN,
  output logic           chainOutN,
  output logic           vecValid,
  output logic [DW-1:0]  vecOut
);
  always_comb begin
    for (int a = 0; a < NREG; a++) st.wrSel[a] = regWr && (int'(regAddr) == a);
    st.wdata   = regWdata;
    st.ackTake = ackReq && !chainInN && anyElig;
  end

  assign irqN      = !anyElig;
  assign chainOutN = chainInN || anyElig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= st.ackTake;
      vecOut   <= st.ackTake ? {vecHi, winId} : '0;
    end
  end

  // R2: a vector only follows an acknowledge that found a request
  a_r2_vec_follows_ack: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ($past(ackReq) && $past(anyElig)));
  // R9: with the chain input inactive, an acknowledge returns nothing
  a_r9_chain_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && chainInN) |=> !vecValid);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       evt,
  input  logic                 regWr,
  input  logic [AW-1:0]        regAddr,
  input  logic [DW-1:0]        regWdata,
  output logic [DW-1:0]        regRdata,
  input  logic                 ackReq,
  input  logic                 chainInN,
  output logic                 chainOutN,
  output logic                 irqN,
  output logic                 vecValid,
  output logic [DW-1:0]        vecOut
);
  strobe_t        st;
  logic           anyElig;
  logic [IDW-1:0] winId;
  logic [3:0]     vecHi;

  irqc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .ackReq(ackReq), .chainInN(chainInN), .anyElig(anyElig), .winId(winId),
    .vecHi(vecHi), .st(st), .irqN(irqN), .chainOutN(chainOutN),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  irqc_datapath dp_i (
    .clk(clk), .rstN(rstN), .st(st), .evt(evt), .rdAddr(regAddr), .rdData(regRdata),
    .anyElig(anyElig), .winId(winId), .vecHi(vecHi)
  );
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] evt = '0;
  logic regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic ackReq = 1'b0;
  logic chainInN = 1'b0;
  logic chainOutN, irqN, vecValid;
  logic [7:0] vecOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqc_top dut_i (.*);

  // behavioural reference state
  bit [15:0] mEn, mPend, mMsk, mSvc;
  bit [7:0]  mVec, mVecOut;
  bit        mVecValid;

  function automatic bit [15:0] mElig();
    bit [15:0] r;
    int top;
    top = -1;
    for (int i = 0; i < 16; i++) if (mSvc[i]) top = i;
    for (int i = 0; i < 16; i++) r[i] = mPend[i] && mMsk[i] && (i > top);
    return r;
  endfunction

  function automatic int mWin();
    bit [15:0] e;
    int w;
    e = mElig();
    w = -1;
    for (int i = 15; i >= 0; i--) if (e[i] && w < 0) w = i;
    return w;
  endfunction

  function automatic bit [7:0] mRead(input int a);
    case (a)
      0: return mEn[7:0];   1: return mEn[15:8];
      2: return mPend[7:0]; 3: return mPend[15:8];
      4: return mMsk[7:0];  5: return mMsk[15:8];
      6: return mSvc[7:0];  7: return mSvc[15:8];
      8: return mVec & 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference update at each edge
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mPend = 0; mMsk = 0; mSvc = 0; mVec = 8'h0F;
      mVecValid = 0; mVecOut = 0;
    end else begin
      int w;
      bit take;
      bit [15:0] clr, sclr;
      w = mWin();
      take = ackReq && !chainInN && (w >= 0);
      clr = 0; sclr = 0;
      if (regWr) begin
        case (int'(regAddr))
          0: begin mEn[7:0] = regWdata; clr[7:0] = ~regWdata; end
          1: begin mEn[15:8] = regWdata; clr[15:8] = ~regWdata; end
          2: clr[7:0] = ~regWdata;
          3: clr[15:8] = ~regWdata;
          4: mMsk[7:0] = regWdata;
          5: mMsk[15:8] = regWdata;
          6: sclr[7:0] = ~regWdata;
          7: sclr[15:8] = ~regWdata;
          default: ;
        endcase
      end
      if (take) clr[w] = 1;
      mPend = (mPend & ~clr) | (evt & mEn);
      if (mVec[3]) begin
        mSvc = mSvc & ~sclr;
        if (take) mSvc[w] = 1;
      end else mSvc = 0;
      if (regWr && regAddr == 4'd8) mVec = regWdata;
      mVecValid = take;
      mVecOut = take ? {mVec_hi_prev(w), 4'(w)} : 8'h00;
    end
  end

  // vector upper nibble uses the register value before this edge's write
  bit [3:0] vecHiHold;
  function automatic bit [3:0] mVec_hi_prev(input int w);
    return vecHiHold;
  endfunction
  always @(negedge clk) vecHiHold = mVec[7:4];

  // cycle-by-cycle comparison after every edge
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      bit anyE;
      anyE = (mElig() != 0);
      chk(irqN == !anyE, "R8 irqN", irqN, !anyE);
      chk(chainOutN == (chainInN || anyE), "R9 chainOutN", chainOutN, chainInN || anyE);
      chk(vecValid == mVecValid, "R2 vecValid", vecValid, mVecValid);
      chk(vecOut == mVecOut, "R2 vecOut", vecOut, mVecOut);
      chk(regRdata == mRead(int'(regAddr)), "R10 readback", regRdata, mRead(int'(regAddr)));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input bit [7:0] d);
    @(negedge clk);
    regWr = 1; regAddr = 4'(a); regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic pulse(input bit [15:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = 0;
  endtask

  task automatic rd(input int a, input bit [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = 4'(a);
    #1;
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic ack(input bit vv, input bit [7:0] exp, input string tag);
    @(negedge clk);
    ackReq = 1;
    @(negedge clk);
    ackReq = 0;
    chk(vecValid == vv, tag, vecValid, vv);
    chk(vecOut == exp, tag, vecOut, exp);
  endtask

  task automatic irqIs(input bit exp, input string tag);
    @(negedge clk);
    chk(irqN == exp, tag, irqN, exp);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    rd(8, 8'h08, "R10 vector reset readback");
    rd(0, 8'h00, "R10 enable reset");
    rd(12, 8'h00, "R10 unused address");
    irqIs(1, "R10 idle request");
    // priority and vector format, automatic mode
    wr(8, 8'h40); wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    pulse(16'h1008);
    irqIs(0, "R8 request asserted");
    ack(1, 8'h4C, "R1 highest channel wins");
    rd(3, 8'h00, "R6 winner pending cleared");
    rd(2, 8'h08, "R6 loser still pending");
    ack(1, 8'h43, "R2 second vector");
    irqIs(1, "R8 request released");
    // disabled channel
    pulse(16'h0200);
    rd(3, 8'h02, "R3 enabled event pends");
    wr(1, 8'h00);
    rd(3, 8'h00, "R3 disable clears pending");
    pulse(16'h0200);
    rd(3, 8'h00, "R3 disabled event ignored");
    wr(1, 8'hFF);
    // mask
    wr(4, 8'hFE);
    pulse(16'h0001);
    rd(2, 8'h01, "R4 masked channel pends");
    irqIs(1, "R4 masked no request");
    wr(4, 8'hFF);
    irqIs(0, "R4 unmask requests");
    ack(1, 8'h40, "R4 unmasked vector");
    // write-zero-to-clear
    pulse(16'h0006);
    wr(2, 8'hFD);
    rd(2, 8'h04, "R5 zero clears bit");
    wr(2, 8'hFF);
    rd(2, 8'h04, "R5 ones leave pending");
    wr(2, 8'h00);
    rd(2, 8'h00, "R5 clear all");
    // software end-of-interrupt and ceiling
    wr(8, 8'h58);
    pulse(16'h0020);
    ack(1, 8'h55, "R7 software mode vector");
    rd(6, 8'h20, "R7 in-service set");
    pulse(16'h0008);
    rd(2, 8'h08, "R8 blocked channel pends");
    irqIs(1, "R8 lower channel blocked");
    pulse(16'h0020);
    irqIs(1, "R8 same channel blocked");
    wr(2, 8'hDF);
    pulse(16'h0080);
    irqIs(0, "R8 higher channel passes");
    ack(1, 8'h57, "R8 nested vector");
    rd(6, 8'hA0, "R7 two in service");
    wr(6, 8'hFF);
    rd(6, 8'hA0, "R5 ones cannot set in-service");
    wr(6, 8'h7F);
    rd(6, 8'h20, "R5 in-service cleared by zero");
    wr(0, 8'hDF);
    rd(6, 8'h20, "R3 disable keeps in-service");
    wr(0, 8'hFF);
    wr(6, 8'h00);
    irqIs(0, "R8 ceiling lifted");
    ack(1, 8'h53, "R8 released channel vector");
    wr(8, 8'h50);
    rd(6, 8'h00, "R7 automatic mode clears in-service");
    // chain
    chainInN = 1;
    pulse(16'h0004);
    irqIs(0, "R9 request independent of chain");
    chk(chainOutN == 1, "R9 chain out held", chainOutN, 1);
    ack(0, 8'h00, "R9 no vector without enable-in");
    rd(2, 8'h04, "R9 pending kept");
    chainInN = 0;
    @(negedge clk);
    chk(chainOutN == 1, "R9 chain out while pending", chainOutN, 1);
    // event in the acknowledge cycle
    @(negedge clk);
    ackReq = 1; evt = 16'h0004;
    @(negedge clk);
    ackReq = 0; evt = 0;
    chk(vecOut == 8'h52, "R6 ack vector with retrigger", vecOut, 8'h52);
    rd(2, 8'h04, "R6 retrigger keeps pending");
    wr(2, 8'h00);
    @(negedge clk);
    chk(chainOutN == 0, "R9 chain passes when idle", chainOutN, 0);
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule